// File: doc/BRIEF.md
# Index Register Address Generator with One-Shot Extension

This block owns the two 16-bit index registers (X and Y) of a small 4-bit processor core. It computes the data-memory address of each register-indirect operand and updates the index registers. The index registers change in three ways: they are loaded, post-incremented after an access, or advanced by 16-bit index arithmetic. The decoder issues one operation per cycle through `valid_i` and `op_i`. The address comes out combinationally in the issue cycle. Register writes take effect at the next rising clock edge.

A prefix operation arms a one-shot extension byte, which changes how the next operation behaves. For a plain indirect access, X becomes a pointer into the bottom 256-entry page and Y a pointer into the top page, both offset by the extension byte. For an immediate add, the extension byte becomes the upper half of a full 16-bit addend. Whatever operation follows the prefix clears the armed state. Data memory and the nibble ALU sit outside this block.

Top module: `idx_agen`

## Requirements
- R1: While `rst_ni` is low and after its release, X and Y read 0, no extension is armed, and `addr_vld_o` and `z_upd_o` are 0 whenever `valid_i` is 0.
- R2: An indirect access (`op_i`=1) with nothing armed drives `addr_vld_o`=1 and `addr_o` equal to the selected index register (`sel_y_i`=0 selects X, 1 selects Y).
- R3: A prefix (`op_i`=5) arms the byte on `ext_byte_i`. A following X-indirect access without post-increment then addresses 0x0000 plus that byte, so the upper byte of `addr_o` is 0x00.
- R4: Under the same conditions a Y-indirect access addresses 0xFF00 plus the byte, so the upper byte of `addr_o` is 0xFF.
- R5: An indirect access with `post_inc_i`=1 always uses the plain register value, even when an extension is armed. It adds 1 to the selected register at the next edge, wrapping 0xFFFF to 0x0000, and never asserts `z_upd_o`.
- R6: An immediate add (`op_i`=2) with nothing armed sign-extends `imm_i` (-128..127) and adds it to the selected register modulo 2^16. It drives `z_upd_o`=1 with `z_o` set exactly when the result is zero.
- R7: An immediate add with an extension armed uses the 16-bit addend {extension byte, `imm_i`}, with the same wrap and Z rules as R6.
- R8: A BA add (`op_i`=3) adds the zero-extended `ba_i` to the selected register with Z updated as in R6. An armed extension has no effect on it.
- R9: Any issued operation other than a prefix (including `op_i`=0, load and the codes 6 and 7) clears an armed extension, so the next access is plain. A second prefix replaces the byte.
- R10: A load (`op_i`=4) writes `ld_data_i` into the selected register. The register not selected by an operation never changes.
- R11: Cycles with `valid_i`=0 neither consume nor change an armed extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 3 | 0 none, 1 indirect access, 2 immediate add, 3 BA add, 4 load, 5 prefix |
| sel_y_i | input | 1 | Index select: 0 X, 1 Y |
| post_inc_i | input | 1 | Indirect access is the post-increment form |
| ext_byte_i | input | 8 | Extension byte captured by a prefix |
| imm_i | input | 8 | Signed immediate for the immediate add |
| ba_i | input | 8 | BA register value for the BA add |
| ld_data_i | input | 16 | Load value |
| addr_o | output | 16 | Effective data-memory address |
| addr_vld_o | output | 1 | `addr_o` is an access this cycle |
| z_o | output | 1 | Zero result of index arithmetic |
| z_upd_o | output | 1 | Z flag is to be written this cycle |
| x_o | output | 16 | Current X register |
| y_o | output | 16 | Current Y register |

## Verification
The interesting collision is an armed extension meeting a post-increment access. In that single cycle the prefix is consumed, the address must ignore the extension byte, and the register increment must still land at the edge. The bench provokes this by issuing a prefix directly before a post-increment access on Y holding 0xFFFF. It then judges the plain address in that cycle, the wrapped register value in the next cycle, and a plain address on the access after that. A long pseudo-random stream also mixes prefixes, idle cycles and every operation, so that this overlap and the prefix-to-add overlap recur against the reference model.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_MEM    = 3'd1,
    OP_ADDI   = 3'd2,
    OP_ADDBA  = 3'd3,
    OP_LOAD   = 3'd4,
    OP_PREFIX = 3'd5
  } idx_op_e;

  localparam int unsigned NUM_IDX = 2;

endpackage

// File: rtl/idx_ext_latch.sv
module idx_ext_latch #(
  parameter int unsigned EXT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             is_prefix_i,
  input  logic [EXT_W-1:0] byte_i,
  output logic             pend_o,
  output logic [EXT_W-1:0] ext_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      ext_o  <= '0;
    end else if (issue_i) begin
      pend_o <= is_prefix_i;
      if (is_prefix_i) ext_o <= byte_i;
    end
  end

  AST_PEND_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !is_prefix_i |=> !pend_o); // R9

  AST_PEND_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && is_prefix_i |=> pend_o && (ext_o == $past(byte_i))); // R3

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(pend_o) && $stable(ext_o)); // R11

endmodule

// File: rtl/idx_regfile.sv
module idx_regfile #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NREG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SW-1:0]            wsel_i,
  input  logic [AW-1:0]            wdata_i,
  output logic [NREG-1:0][AW-1:0]  regs_o
);

  localparam int unsigned SW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [AW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q[g] <= '0;
      else if (we_i && wsel_i == SW'(g))    q[g] <= wdata_i;
    end
    assign regs_o[g] = q[g];

    AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wsel_i == SW'(g)) |=> $stable(q[g])); // R10
  end

endmodule

// File: rtl/idx_addr_mux.sv
module idx_addr_mux #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]   base_i,
  input  logic            sel_y_i,
  input  logic            post_inc_i,
  input  logic            pend_i,
  input  logic [HW-1:0]   ext_i,
  output logic [AW-1:0]   addr_o
);

  localparam int unsigned HW = AW / 2;

  logic [HW-1:0] page;

  // X maps to the bottom page, Y to the top page
  assign page   = sel_y_i ? '1 : '0;
  assign addr_o = (pend_i && !post_inc_i) ? {page, ext_i} : base_i;

endmodule

// File: rtl/idx_update.sv
module idx_update
  import idx_agen_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  idx_op_e         op_i,
  input  logic            post_inc_i,
  input  logic [AW-1:0]   base_i,
  input  logic [HW-1:0]   imm_i,
  input  logic [HW-1:0]   ba_i,
  input  logic [AW-1:0]   ld_i,
  input  logic            pend_i,
  input  logic [HW-1:0]   ext_i,
  output logic            we_o,
  output logic [AW-1:0]   wdata_o,
  output logic            z_o,
  output logic            z_upd_o
);

  localparam int unsigned HW = AW / 2;

  logic [AW-1:0] addend;
  logic [AW-1:0] sum;

  always_comb begin
    addend = '0;
    unique case (op_i)
      OP_MEM:   addend = AW'(1);
      OP_ADDI:  addend = pend_i ? {ext_i, imm_i} : {{HW{imm_i[HW-1]}}, imm_i};
      OP_ADDBA: addend = {{HW{1'b0}}, ba_i};
      default:  addend = '0;
    endcase
  end

  assign sum = base_i + addend;

  always_comb begin
    we_o    = 1'b0;
    wdata_o = sum;
    z_upd_o = 1'b0;
    unique case (op_i)
      OP_MEM:            we_o = post_inc_i;
      OP_ADDI, OP_ADDBA: begin
        we_o    = 1'b1;
        z_upd_o = 1'b1;
      end
      OP_LOAD: begin
        we_o    = 1'b1;
        wdata_o = ld_i;
      end
      default: ;
    endcase
  end

  assign z_o = (sum == '0);

endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            sel_y_i,
  input  logic            post_inc_i,
  input  logic [AW/2-1:0] ext_byte_i,
  input  logic [AW/2-1:0] imm_i,
  input  logic [AW/2-1:0] ba_i,
  input  logic [AW-1:0]   ld_data_i,
  output logic [AW-1:0]   addr_o,
  output logic            addr_vld_o,
  output logic            z_o,
  output logic            z_upd_o,
  output logic [AW-1:0]   x_o,
  output logic [AW-1:0]   y_o
);

  localparam int unsigned HW = AW / 2;

  idx_op_e                     op;
  logic                        pend;
  logic [HW-1:0]               ext;
  logic [AW-1:0]               base;
  logic                        we;
  logic [AW-1:0]               wdata;
  logic [NUM_IDX-1:0][AW-1:0]  regs;

  assign op   = valid_i ? idx_op_e'(op_i) : OP_NONE;
  assign base = regs[sel_y_i];

  idx_ext_latch #(.EXT_W(HW)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (valid_i),
    .is_prefix_i (op == OP_PREFIX),
    .byte_i      (ext_byte_i),
    .pend_o      (pend),
    .ext_o       (ext)
  );

  idx_addr_mux #(.AW(AW)) u_addr (
    .base_i     (base),
    .sel_y_i    (sel_y_i),
    .post_inc_i (post_inc_i),
    .pend_i     (pend),
    .ext_i      (ext),
    .addr_o     (addr_o)
  );

  idx_update #(.AW(AW)) u_upd (
    .op_i       (op),
    .post_inc_i (post_inc_i),
    .base_i     (base),
    .imm_i      (imm_i),
    .ba_i       (ba_i),
    .ld_i       (ld_data_i),
    .pend_i     (pend),
    .ext_i      (ext),
    .we_o       (we),
    .wdata_o    (wdata),
    .z_o        (z_o),
    .z_upd_o    (z_upd_o)
  );

  idx_regfile #(.AW(AW), .NREG(NUM_IDX)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wsel_i  (sel_y_i),
    .wdata_i (wdata),
    .regs_o  (regs)
  );

  assign x_o        = regs[0];
  assign y_o        = regs[1];
  assign addr_vld_o = (op == OP_MEM);

  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && post_inc_i |=>
      (($past(sel_y_i) ? y_o : x_o) == AW'($past(base) + AW'(1)))); // R5

  AST_MEM_NO_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> !z_upd_o); // R5

  AST_X_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o && pend && !post_inc_i && !sel_y_i |-> addr_o[AW-1:HW] == '0); // R3

  AST_Y_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o && pend && !post_inc_i && sel_y_i |-> addr_o[AW-1:HW] == '1); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !addr_vld_o && !z_upd_o); // R1

endmodule

// File: tb/idx_agen_tb.sv
module idx_agen_tb;
  import idx_agen_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        vld;
    logic [15:0] addr;
    logic        zu;
    logic        z;
    logic [15:0] x;
    logic [15:0] y;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        sel_y_i = 1'b0;
  logic        post_inc_i = 1'b0;
  logic [7:0]  ext_byte_i = '0;
  logic [7:0]  imm_i = '0;
  logic [7:0]  ba_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [15:0] addr_o, x_o, y_o;
  logic        addr_vld_o, z_o, z_upd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t  q[$];
  string tq[$];

  logic [15:0] mx = '0, my = '0;
  logic        mpend = 1'b0;
  logic [7:0]  mext = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_agen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .sel_y_i(sel_y_i), .post_inc_i(post_inc_i), .ext_byte_i(ext_byte_i),
    .imm_i(imm_i), .ba_i(ba_i), .ld_data_i(ld_data_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .z_o(z_o), .z_upd_o(z_upd_o),
    .x_o(x_o), .y_o(y_o)
  );

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b0;
    e = '{vld:1'b0, addr:16'h0, zu:1'b0, z:1'b0, x:mx, y:my};
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic step(input logic [2:0] op, input logic sel, input logic pinc,
                      input logic [7:0] eb, input logic [7:0] imm,
                      input logic [7:0] ba, input logic [15:0] ld,
                      input string tag);
    exp_t        e;
    logic [15:0] base, res;
    logic        wr;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; sel_y_i = sel; post_inc_i = pinc;
    ext_byte_i = eb; imm_i = imm; ba_i = ba; ld_data_i = ld;
    base = sel ? my : mx;
    e = '{vld:1'b0, addr:16'h0, zu:1'b0, z:1'b0, x:mx, y:my};
    wr = 1'b0; res = base;
    case (op)
      3'd1: begin
        e.vld  = 1'b1;
        e.addr = (mpend && !pinc) ? {(sel ? 8'hFF : 8'h00), mext} : base;
        if (pinc) begin wr = 1'b1; res = base + 16'd1; end
      end
      3'd2: begin
        res  = base + (mpend ? {mext, imm} : {{8{imm[7]}}, imm});
        wr   = 1'b1; e.zu = 1'b1; e.z = (res == 16'h0);
      end
      3'd3: begin
        res  = base + {8'h00, ba};
        wr   = 1'b1; e.zu = 1'b1; e.z = (res == 16'h0);
      end
      3'd4: begin wr = 1'b1; res = ld; end
      default: ;
    endcase
    q.push_back(e);
    tq.push_back(tag);
    if (wr) begin
      if (sel) my = res; else mx = res;
    end
    mpend = (op == 3'd5);
    if (op == 3'd5) mext = eb;
  endtask

  // monitor: pops one expected item per cycle, samples late in the cycle
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        bit bad;
        e = q.pop_front();
        t = tq.pop_front();
        bad = (addr_vld_o !== e.vld) || (z_upd_o !== e.zu) ||
              (x_o !== e.x) || (y_o !== e.y) ||
              (e.vld && addr_o !== e.addr) || (e.zu && z_o !== e.z);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: vld=%0b addr=%h zu=%0b z=%0b x=%h y=%h expected vld=%0b addr=%h zu=%0b z=%0b x=%h y=%h",
                   t, addr_vld_o, addr_o, z_upd_o, z_o, x_o, y_o,
                   e.vld, e.addr, e.zu, e.z, e.x, e.y);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle("R1 in reset");
    idle("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1 after reset");
    step(3'd4, 0, 0, 8'h00, 8'h00, 8'h00, 16'h1234, "R10 load X");
    step(3'd4, 1, 0, 8'h00, 8'h00, 8'h00, 16'hFFFF, "R10 load Y");
    step(3'd1, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R2 plain X access");
    step(3'd5, 0, 0, 8'hEE, 8'h00, 8'h00, 16'h0,    "R3 prefix");
    step(3'd1, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R3 X bottom page");
    step(3'd5, 1, 0, 8'h5A, 8'h00, 8'h00, 16'h0,    "R4 prefix");
    idle("R11 idle keeps prefix");
    idle("R11 idle keeps prefix");
    step(3'd1, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R4 Y top page after idles");
    step(3'd5, 1, 0, 8'h33, 8'h00, 8'h00, 16'h0,    "R5 prefix");
    step(3'd1, 1, 1, 8'h00, 8'h00, 8'h00, 16'h0,    "R5 post-inc ignores prefix");
    step(3'd1, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R5 wrap to 0 and R9 consumed");
    step(3'd2, 0, 0, 8'h00, 8'h80, 8'h00, 16'h0,    "R6 add -128");
    step(3'd4, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0005, "R10 load Y");
    step(3'd2, 1, 0, 8'h00, 8'hFB, 8'h00, 16'h0,    "R6 add -5 gives zero");
    step(3'd5, 0, 0, 8'h12, 8'h00, 8'h00, 16'h0,    "R7 prefix");
    step(3'd2, 0, 0, 8'h00, 8'h34, 8'h00, 16'h0,    "R7 16-bit add");
    step(3'd5, 0, 0, 8'hFF, 8'h00, 8'h00, 16'h0,    "R7 prefix");
    step(3'd2, 0, 0, 8'h00, 8'h18, 8'h00, 16'h0,    "R7 negative 16-bit add");
    step(3'd5, 0, 0, 8'h80, 8'h00, 8'h00, 16'h0,    "R8 prefix");
    step(3'd3, 0, 0, 8'h00, 8'h00, 8'hF0, 16'h0,    "R8 BA add ignores prefix");
    step(3'd3, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R8 BA add zero");
    step(3'd5, 0, 0, 8'h44, 8'h00, 8'h00, 16'h0,    "R9 prefix");
    step(3'd0, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R9 none consumes");
    step(3'd1, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R9 plain access");
    step(3'd5, 0, 0, 8'h44, 8'h00, 8'h00, 16'h0,    "R9 prefix");
    step(3'd4, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0000, "R9 load consumes");
    step(3'd1, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R9 plain access");
    step(3'd5, 1, 0, 8'h01, 8'h00, 8'h00, 16'h0,    "R9 prefix");
    step(3'd5, 1, 0, 8'h02, 8'h00, 8'h00, 16'h0,    "R9 prefix replaced");
    step(3'd1, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R9 second byte used");
    step(3'd7, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0,    "R9 unused code");
    idle("R1 idle quiet");

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = 3'(lfsr[2:0] % 3'd6);
      if (lfsr[11:10] == 2'b00)
        idle("R11 random idle");
      else
        step(op, lfsr[3], lfsr[4], lfsr[15:8], lfsr[12:5], lfsr[10:3],
             {lfsr[7:0], lfsr[15:8]}, "R2 R5 R6 R7 R8 R10 random mix");
    end
    idle("R1 tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule